// File: doc/BRIEF.md
# Periodic / One-Shot Comparator Channel

This block is one channel of a free-running timer. It watches a 32-bit main counter that lives elsewhere and compares it against its own comparator. It emits a single-cycle match pulse when the counter steps onto the comparator value. Interrupt delivery is handled downstream. The channel runs in one of two modes, chosen by a configuration bit.

In one-shot mode the comparator is a plain register. A comparator value that is already behind the counter fires only after the counter wraps. In periodic mode the channel also holds a reload rate. After every match, and whenever counting restarts or the counter is reloaded, the channel computes a new comparator with a sequential divider. That value is the first point on the comparator's rate grid that lies strictly ahead of the counter. Software loads the rate and the comparator through a masked write port. A self-clearing value-set bit in the configuration decides whether a periodic write also moves the live comparator.

Top module: `cmp_channel`

## Requirements
- R1: After synchronous reset the comparator reads 0xFFFFFFFF, the configuration reads 0, the match output is 0 and the rate is 0.
- R2: In one-shot mode (config bit 3 = 0), a comparator write replaces exactly the comparator bits selected by the write mask.
- R3: In periodic mode (config bit 3 = 1), a comparator write merges the data into the rate. The live comparator takes that merged rate only when the value-set bit (config bit 6) was 1; otherwise the comparator is unchanged.
- R4: Config bit 6 reads 0 after any comparator write.
- R5: Whenever config bit 3 is 0 the rate is held at 0, so a later periodic match leaves the comparator unchanged.
- R6: While counting is enabled in both the current and the previous cycle, a counter value that differs from the previous one and equals the comparator makes match_o high for exactly one cycle, in the cycle after the counter value is presented.
- R7: No match occurs while counting is disabled. In the cycle counting is re-enabled, or the reload strobe is high, the channel re-arms against the present counter without matching, even if the counter equals the comparator.
- R8: After a periodic match with a nonzero rate, the comparator becomes cmp + ((count − cmp)/rate + 1)·rate in 32-bit modulo arithmetic, within CW+4 cycles.
- R9: In periodic mode with a nonzero rate, a rising counter enable, or a reload strobe while enabled, recomputes the comparator with the same formula against the counter value of that cycle.
- R10: In one-shot mode a comparator behind the counter is not corrected: it keeps its value and no match occurs as the counter runs away from it.
- R11: While a recomputation is in progress, matches against the old comparator are ignored.
- R12: A comparator write during a recomputation cancels it; the computed value is never written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CW | Main counter value |
| cnt_en_i | input | 1 | Main counter is counting |
| cnt_load_i | input | 1 | Main counter was reloaded this cycle |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data (bit 3 periodic, bit 6 value-set) |
| cfg_wmask_i | input | 8 | Configuration write bit mask |
| cmp_wr_i | input | 1 | Comparator write strobe |
| cmp_wdata_i | input | CW | Comparator write data |
| cmp_wmask_i | input | CW | Comparator write bit mask |
| match_o | output | 1 | One-cycle match pulse |
| cmp_rd_o | output | CW | Live comparator value |
| cfg_rd_o | output | 8 | Configuration value |

## Verification
The bench goes after the catch-up arithmetic. It uses random comparator, counter and rate triples, including cases where the counter lies behind the comparator in modular terms. A design that skipped the "+1" or did not wrap at 32 bits would land on or behind the counter and stall until a wrap. It also tests a counter that already sits on the comparator when counting restarts or reloads. A design without re-arming would fire spuriously there. It probes the busy window with a counter that steps back onto the old comparator; an unguarded design pulses twice. It writes the comparator during a recomputation; a design without cancellation would overwrite software's value. Finally, it checks that the value-set bit clears itself and gates the live comparator, and that a one-shot comparator left behind stays untouched.

// File: rtl/cmpch_pkg.sv
package cmpch_pkg;
  localparam int CFG_W   = 8;
  localparam int PER_BIT = 3;  // periodic mode select
  localparam int VS_BIT  = 6;  // arm comparator load on next periodic write
endpackage

// File: rtl/cmpch_regs.sv
module cmpch_regs
  import cmpch_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic [CFG_W-1:0] cfg_wmask_i,
  input  logic             cmp_wr_i,
  input  logic [CW-1:0]    cmp_wdata_i,
  input  logic [CW-1:0]    cmp_wmask_i,
  input  logic             wb_en_i,
  input  logic [CW-1:0]    wb_val_i,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CW-1:0]    cmp_q,
  output logic [CW-1:0]    rate_q
);
  logic [CFG_W-1:0] cfg_n;
  logic [CW-1:0]    rate_m, cmp_m;

  always_comb begin
    cfg_n = cfg_wr_i ? ((cfg_q & ~cfg_wmask_i) | (cfg_wdata_i & cfg_wmask_i)) : cfg_q;
    if (cmp_wr_i) cfg_n[VS_BIT] = 1'b0;
    rate_m = (rate_q & ~cmp_wmask_i) | (cmp_wdata_i & cmp_wmask_i);
    cmp_m  = (cmp_q  & ~cmp_wmask_i) | (cmp_wdata_i & cmp_wmask_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      cmp_q  <= '1;
      rate_q <= '0;
    end else begin
      cfg_q <= cfg_n;
      if (cmp_wr_i) begin
        if (cfg_q[PER_BIT]) begin
          rate_q <= rate_m;
          if (cfg_q[VS_BIT]) cmp_q <= rate_m;
        end else begin
          cmp_q <= cmp_m;
        end
      end else if (wb_en_i) begin
        cmp_q <= wb_val_i;
      end
      if (!cfg_n[PER_BIT]) rate_q <= '0;
    end
  end

  // R4: value-set bit is gone after a comparator write
  p_vs_clear_r4: assert property (@(posedge clk) disable iff (rst)
    cmp_wr_i |=> !cfg_q[VS_BIT]);
  // R5: rate held at zero outside periodic mode
  p_rate_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !cfg_q[PER_BIT] |-> rate_q == '0);
  // R3: unarmed periodic write leaves the live comparator alone
  p_keep_cmp_r3: assert property (@(posedge clk) disable iff (rst)
    (cmp_wr_i && cfg_q[PER_BIT] && !cfg_q[VS_BIT]) |=> $stable(cmp_q));
endmodule

// File: rtl/cmpch_detect.sv
module cmpch_detect #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic          cnt_en_i,
  input  logic          cnt_load_i,
  input  logic          hold_i,
  input  logic [CW-1:0] cmp_i,
  output logic          hit_o,
  output logic          en_rise_o,
  output logic          match_o
);
  logic [CW-1:0] cnt_q;
  logic          en_q;

  assign en_rise_o = cnt_en_i && !en_q;
  assign hit_o = cnt_en_i && en_q && !cnt_load_i && !hold_i &&
                 (cnt_i != cnt_q) && (cnt_i == cmp_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      en_q    <= 1'b0;
      match_o <= 1'b0;
    end else begin
      cnt_q   <= cnt_i;
      en_q    <= cnt_en_i;
      match_o <= hit_o;
    end
  end

  // R7: a stopped counter never matches
  p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !cnt_en_i |=> !match_o);
endmodule

// File: rtl/cmpch_div.sv
module cmpch_div #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [CW-1:0] dividend_i,
  input  logic [CW-1:0] divisor_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] quot_o
);
  localparam int SW = $clog2(CW + 1);

  logic [CW-1:0] rem_q, den_q;
  logic [SW-1:0] step_q;
  logic [CW:0]   shifted, trial;

  assign shifted = {rem_q, quot_o[CW-1]};
  assign trial   = shifted - {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      den_q  <= '0;
      quot_o <= '0;
      step_q <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      den_q  <= divisor_i;
      quot_o <= dividend_i;
      step_q <= SW'(CW);
      busy_o <= 1'b1;
      done_o <= 1'b0;
    end else if (abort_i) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else if (busy_o) begin
      if (!trial[CW]) begin
        rem_q  <= trial[CW-1:0];
        quot_o <= {quot_o[CW-2:0], 1'b1};
      end else begin
        rem_q  <= shifted[CW-1:0];
        quot_o <= {quot_o[CW-2:0], 1'b0};
      end
      step_q <= step_q - SW'(1);
      if (step_q == SW'(1)) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  // R8: a result is only announced at the end of a busy run
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy_o));
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmpch_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    cnt_i,
  input  logic             cnt_en_i,
  input  logic             cnt_load_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic [CFG_W-1:0] cfg_wmask_i,
  input  logic             cmp_wr_i,
  input  logic [CW-1:0]    cmp_wdata_i,
  input  logic [CW-1:0]    cmp_wmask_i,
  output logic             match_o,
  output logic [CW-1:0]    cmp_rd_o,
  output logic [CFG_W-1:0] cfg_rd_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [CW-1:0]    cmp_q, rate_q, quot;
  logic [CW-1:0]    base_q, step_q, wb_val;
  logic             hit, en_rise, div_busy, div_done, start, abort, wb_en, periodic;

  assign periodic = cfg_q[PER_BIT];

  cmpch_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_wmask_i(cfg_wmask_i),
    .cmp_wr_i(cmp_wr_i), .cmp_wdata_i(cmp_wdata_i), .cmp_wmask_i(cmp_wmask_i),
    .wb_en_i(wb_en), .wb_val_i(wb_val),
    .cfg_q(cfg_q), .cmp_q(cmp_q), .rate_q(rate_q)
  );

  cmpch_detect #(.CW(CW)) u_detect (
    .clk(clk), .rst(rst),
    .cnt_i(cnt_i), .cnt_en_i(cnt_en_i), .cnt_load_i(cnt_load_i),
    .hold_i(div_busy || div_done), .cmp_i(cmp_q),
    .hit_o(hit), .en_rise_o(en_rise), .match_o(match_o)
  );

  assign start = periodic && (rate_q != '0) && !cmp_wr_i &&
                 (hit || en_rise || (cnt_load_i && cnt_en_i));
  assign abort = cmp_wr_i || !periodic;

  cmpch_div #(.CW(CW)) u_div (
    .clk(clk), .rst(rst),
    .start_i(start), .abort_i(abort),
    .dividend_i(cnt_i - cmp_q), .divisor_i(rate_q),
    .busy_o(div_busy), .done_o(div_done), .quot_o(quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      step_q <= '0;
    end else if (start) begin
      base_q <= cmp_q;
      step_q <= rate_q;
    end
  end

  assign wb_val = base_q + (quot + CW'(1)) * step_q;
  assign wb_en  = div_done && periodic && !cmp_wr_i;

  assign cmp_rd_o = cmp_q;
  assign cfg_rd_o = cfg_q;

  // R11: no pulse comes out of a cycle spent recomputing
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    div_busy |=> !match_o);
endmodule

// File: tb/test_cmp_channel.sv
module test_cmp_channel;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cnt_i = '0;
  logic          cnt_en_i = 1'b0, cnt_load_i = 1'b0;
  logic          cfg_wr_i = 1'b0;
  logic [7:0]    cfg_wdata_i = '0, cfg_wmask_i = '0;
  logic          cmp_wr_i = 1'b0;
  logic [CW-1:0] cmp_wdata_i = '0, cmp_wmask_i = '0;
  logic          match_o;
  logic [CW-1:0] cmp_rd_o;
  logic [7:0]    cfg_rd_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_channel #(.CW(CW)) i_cmp_channel (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .cnt_en_i(cnt_en_i), .cnt_load_i(cnt_load_i),
    .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_wmask_i(cfg_wmask_i),
    .cmp_wr_i(cmp_wr_i), .cmp_wdata_i(cmp_wdata_i), .cmp_wmask_i(cmp_wmask_i),
    .match_o(match_o), .cmp_rd_o(cmp_rd_o), .cfg_rd_o(cfg_rd_o)
  );

  function automatic logic [31:0] next_cmp(input logic [31:0] c, x, r);
    logic [31:0] d;
    d = x - c;
    return c + (d / r + 32'd1) * r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tk();
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [7:0] d, input logic [7:0] m);
    cfg_wr_i = 1'b1; cfg_wdata_i = d; cfg_wmask_i = m;
    tk();
    cfg_wr_i = 1'b0;
  endtask

  task automatic wr_cmp(input logic [31:0] d, input logic [31:0] m);
    cmp_wr_i = 1'b1; cmp_wdata_i = d; cmp_wmask_i = m;
    tk();
    cmp_wr_i = 1'b0;
  endtask

  task automatic set_cnt(input logic [31:0] v);
    cnt_i = v;
    tk();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] c, x, r, y, e1, e2;
    int hits;
    void'($urandom(32'd17));
    repeat (3) tk();
    rst = 1'b0;
    tk();
    chk("R1 cmp reset", cmp_rd_o, 32'hFFFF_FFFF);
    chk("R1 cfg reset", {24'd0, cfg_rd_o}, 32'd0);
    chk("R1 match reset", {31'd0, match_o}, 32'd0);

    // R2 masked one-shot writes
    wr_cmp(32'h1234_5678, '1);
    wr_cmp(32'hAABB_0000, 32'hFFFF_0000);
    chk("R2 masked cmp", cmp_rd_o, 32'hAABB_5678);

    // R6 basic match and single pulse
    wr_cmp(32'd100, '1);
    cnt_i = 32'd98; cnt_en_i = 1'b1; tk();
    set_cnt(32'd99);
    chk("R6 no early match", {31'd0, match_o}, 32'd0);
    set_cnt(32'd100);
    chk("R6 match pulse", {31'd0, match_o}, 32'd1);
    set_cnt(32'd100);
    chk("R6 pulse one cycle", {31'd0, match_o}, 32'd0);

    // R7 disabled, re-enable and reload re-arm
    cnt_en_i = 1'b0;
    set_cnt(32'd150);
    set_cnt(32'd100);
    chk("R7 no match disabled", {31'd0, match_o}, 32'd0);
    cnt_en_i = 1'b1; tk();
    chk("R7 no match on enable", {31'd0, match_o}, 32'd0);
    set_cnt(32'd101);
    set_cnt(32'd100);
    chk("R7 match after re-arm", {31'd0, match_o}, 32'd1);
    set_cnt(32'd101);
    cnt_i = 32'd100; cnt_load_i = 1'b1; tk(); cnt_load_i = 1'b0;
    chk("R7 no match on reload", {31'd0, match_o}, 32'd0);

    // R10 one-shot comparator behind the counter
    wr_cmp(32'd50, '1);
    hits = 0;
    for (int i = 60; i <= 70; i++) begin
      set_cnt(i);
      hits += int'(match_o);
    end
    chk("R10 no match behind", hits, 0);
    chk("R10 cmp uncorrected", cmp_rd_o, 32'd50);

    // R3 / R4 periodic writes and value-set
    wr_cfg(8'h48, 8'hFF);
    chk("R3 cfg written", {24'd0, cfg_rd_o}, 32'h48);
    wr_cmp(32'd500, '1);
    chk("R3 armed write loads cmp", cmp_rd_o, 32'd500);
    chk("R4 value-set cleared", {24'd0, cfg_rd_o}, 32'h08);
    wr_cmp(32'd700, '1);
    chk("R3 unarmed write keeps cmp", cmp_rd_o, 32'd500);

    // R8 periodic advance, R11 hold during recompute
    set_cnt(32'd499);
    set_cnt(32'd500);
    chk("R8 periodic match", {31'd0, match_o}, 32'd1);
    set_cnt(32'd501);
    set_cnt(32'd500);
    chk("R11 ignored during recompute", {31'd0, match_o}, 32'd0);
    repeat (40) tk();
    chk("R8 advanced cmp", cmp_rd_o, 32'd1200);

    // R12 write cancels recompute
    set_cnt(32'd1199);
    set_cnt(32'd1200);
    chk("R12 match before cancel", {31'd0, match_o}, 32'd1);
    wr_cmp(32'd900, '1);
    repeat (40) tk();
    chk("R12 cmp kept after cancel", cmp_rd_o, 32'd1200);

    // R5 leaving periodic mode zeroes the rate
    wr_cfg(8'h00, 8'h08);
    wr_cfg(8'h08, 8'h08);
    set_cnt(32'd1199);
    set_cnt(32'd1200);
    chk("R5 match with zero rate", {31'd0, match_o}, 32'd1);
    repeat (40) tk();
    chk("R5 cmp unchanged", cmp_rd_o, 32'd1200);

    // Random R9 / R8 / R6
    for (int it = 0; it < 25; it++) begin
      c = $urandom; x = $urandom; y = $urandom;
      r = ($urandom % 100000) + 100;
      cnt_en_i = 1'b0; tk();
      wr_cfg(8'h00, 8'h48);
      wr_cmp(c, '1);
      wr_cfg(8'h08, 8'h08);
      wr_cmp(r, '1);
      cnt_i = x; tk();
      cnt_en_i = 1'b1;
      repeat (45) tk();
      e1 = next_cmp(c, x, r);
      chk("R9 recompute on enable", cmp_rd_o, e1);
      set_cnt(e1 - 32'd1);
      set_cnt(e1);
      chk("R6 random match", {31'd0, match_o}, 32'd1);
      repeat (45) tk();
      e2 = e1 + r;
      chk("R8 random advance", cmp_rd_o, e2);
      cnt_i = y; cnt_load_i = 1'b1; tk(); cnt_load_i = 1'b0;
      repeat (45) tk();
      chk("R9 recompute on reload", cmp_rd_o, next_cmp(e2, y, r));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule